// File: doc/BRIEF.md
# Wake-Cause Interrupt Flag Register

This block keeps a small set of sticky flags that tell software why the processor woke up or was interrupted. A push-button press and both directions of the power-good signal each latch a flag. The flag stays set until software writes a zero to it, or until an automatic clear event occurs. The two power flags raise a single interrupt line, which an enable input gates.

The push-button and power-good pins are asynchronous. Each passes through a two-flop synchronizer and then an edge detector before it can set a flag. The power-fall flag is suppressed when the current wake source is the push-button or the wake timer, because the device then starts in brownout operation without a real loss of power. A request for sleep or LCD-only mode clears the push-button flag. Two further bits are plain read/write storage for a neighbouring collision-interrupt source. All flags share one 8-bit register, and software decodes them by position.

Top module: `wake_flag_reg`

## Requirements
- R1: After a synchronous reset, `flags` reads 0x00 and `irq` is 0.
- R2: The push-button flag (bit 4) sets at the clock edge two cycles after the edge at which `btn_in` is first sampled high, following at least one sample low.
- R3: Bit 4 clears at any clock edge where `sleep_req` or `lcd_req` is high and no push-button set event occurs at that edge.
- R4: The power-rise flag (bit 6) sets on a low-to-high change of `pwr_good_in`, with the same two-cycle latency as R2.
- R5: The power-fall flag (bit 7) sets on a high-to-low change of `pwr_good_in`, with the same latency, when `wake_src` is 0 (none) or 3 (other) at the setting edge.
- R6: Bit 7 is not set by a falling power-good edge if `wake_src` is 1 (push-button) or 2 (wake timer) at the setting edge.
- R7: A write (`wr_en` high) with a 0 in bit 4, 6 or 7 clears that flag. A 1 in that bit leaves the flag unchanged. No flag changes without a set event, a write of 0 or an automatic clear.
- R8: When a set event and a clear (a written 0 or an automatic clear) fall on the same edge, the flag ends up set.
- R9: Bits 2 and 3 take the written value on every write and hold it otherwise. Bits 0, 1 and 5 always read 0.
- R10: `irq` equals `irq_en` AND (bit 6 OR bit 7), combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| btn_in | input | 1 | Asynchronous push-button pin |
| pwr_good_in | input | 1 | Asynchronous power-good indication |
| sleep_req | input | 1 | Sleep-mode request; clears the push-button flag |
| lcd_req | input | 1 | LCD-only mode request; clears the push-button flag |
| wake_src | input | 2 | Current wake reason: 0 none, 1 push-button, 2 wake timer, 3 other |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| irq_en | input | 1 | Power interrupt enable |
| flags | output | 8 | Flag register contents |
| irq | output | 1 | Shared power interrupt request |

## Verification
The properties that relate an edge to a flag take the edge from the detector output. They therefore assume that `wake_src`, `sleep_req`, `lcd_req` and the write port mean something only at the sampling edge, and that the pins may change at any cycle. The stimulus changes every input only at the falling clock edge, so each value is stable across the edge that samples it. The random phase toggles the pins with low probability so that single-cycle pulses and held levels both occur. It also varies `wake_src` freely, which covers both the masked and the unmasked power-fall cases.

// File: rtl/wake_flag_pkg.sv
package wake_flag_pkg;

    localparam int REG_W     = 8;
    localparam int N_EVT     = 3;
    localparam int BIT_COL0  = 2;
    localparam int BIT_COL1  = 3;
    localparam int BIT_BTN   = 4;
    localparam int BIT_PRISE = 6;
    localparam int BIT_PFALL = 7;

    // event slot indices inside evt_vec_t
    localparam int EV_BTN   = 0;
    localparam int EV_PRISE = 1;
    localparam int EV_PFALL = 2;

    typedef enum logic [1:0] {
        WS_NONE   = 2'd0,
        WS_BUTTON = 2'd1,
        WS_TIMER  = 2'd2,
        WS_OTHER  = 2'd3
    } wake_src_e;

    typedef struct packed {
        logic pfall;
        logic prise;
        logic btn;
    } evt_vec_t;

    // register position of each event flag
    function automatic int evt_pos(input int e);
        case (e)
            EV_BTN:   return BIT_BTN;
            EV_PRISE: return BIT_PRISE;
            default:  return BIT_PFALL;
        endcase
    endfunction

    // a wake straight into brownout must not look like a power loss
    function automatic logic fall_masked(input logic [1:0] ws);
        return (ws == WS_BUTTON) || (ws == WS_TIMER);
    endfunction

endpackage

// File: rtl/wf_sync.sv
module wf_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) st[i] <= '0;
        end else begin
            st[0] <= d;
            for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
        end
    end

    assign q = st[STAGES-1];
endmodule

// File: rtl/wf_edge.sv
module wf_edge #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= '0;
        else     prev <= d;
    end

    assign rise = d & ~prev;
    assign fall = ~d & prev;
endmodule

// File: rtl/wf_flag_bit.sv
module wf_flag_bit (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic q
);
    // set has priority over any clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst)        q <= 1'b0;
        else if (set_i) q <= 1'b1;
        else if (clr_i) q <= 1'b0;
    end
endmodule

// File: rtl/wake_flag_reg.sv
module wake_flag_reg
    import wake_flag_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             btn_in,
    input  logic             pwr_good_in,
    input  logic             sleep_req,
    input  logic             lcd_req,
    input  logic [1:0]       wake_src,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             irq_en,
    output logic [REG_W-1:0] flags,
    output logic             irq
);
    localparam int N_PIN = 2;   // [0] push-button, [1] power-good

    logic [N_PIN-1:0] pin_s, pin_rise, pin_fall;
    logic             btn_rise, pg_rise, pg_fall;
    evt_vec_t         set_e, clr_e, q_e;
    logic [1:0]       col_q;

    wf_sync #(.W(N_PIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({pwr_good_in, btn_in}),
        .q   (pin_s)
    );

    wf_edge #(.W(N_PIN)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .d    (pin_s),
        .rise (pin_rise),
        .fall (pin_fall)
    );

    assign btn_rise = pin_rise[0];
    assign pg_rise  = pin_rise[1];
    assign pg_fall  = pin_fall[1];

    always_comb begin
        set_e.btn   = btn_rise;
        set_e.prise = pg_rise;
        set_e.pfall = pg_fall & ~fall_masked(wake_src);
        clr_e.btn   = (wr_en & ~wr_data[BIT_BTN]) | sleep_req | lcd_req;
        clr_e.prise = wr_en & ~wr_data[BIT_PRISE];
        clr_e.pfall = wr_en & ~wr_data[BIT_PFALL];
    end

    logic [N_EVT-1:0] set_v, clr_v, q_v;
    assign set_v = set_e;
    assign clr_v = clr_e;
    assign q_e   = q_v;

    for (genvar e = 0; e < N_EVT; e++) begin : g_evt
        wf_flag_bit u_bit (
            .clk   (clk),
            .rst   (rst),
            .set_i (set_v[e]),
            .clr_i (clr_v[e]),
            .q     (q_v[e])
        );
    end

    // collision flags: ordinary read/write storage
    always_ff @(posedge clk) begin
        if (rst)        col_q <= '0;
        else if (wr_en) col_q <= wr_data[BIT_COL1:BIT_COL0];
    end

    always_comb begin
        // unimplemented positions read zero; write data there is discarded
        flags = wr_data & '0;
        flags[BIT_COL1:BIT_COL0] = col_q;
        for (int e = 0; e < N_EVT; e++) flags[evt_pos(e)] = q_v[e];
    end

    assign irq = irq_en & (q_e.prise | q_e.pfall);
endmodule

// File: rtl/wake_flag_chk.sv
module wake_flag_chk
    import wake_flag_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       btn_rise,
    input logic       pg_rise,
    input logic       pg_fall,
    input logic       sleep_req,
    input logic       lcd_req,
    input logic [1:0] wake_src,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic       irq_en,
    input logic [7:0] flags,
    input logic       irq
);
    p_btn_set_r2: assert property (@(posedge clk) disable iff (rst)
        btn_rise |=> flags[BIT_BTN]);

    p_auto_clear_r3: assert property (@(posedge clk) disable iff (rst)
        ((sleep_req || lcd_req) && !btn_rise) |=> !flags[BIT_BTN]);

    p_rise_set_r4: assert property (@(posedge clk) disable iff (rst)
        pg_rise |=> flags[BIT_PRISE]);

    p_fall_set_r5: assert property (@(posedge clk) disable iff (rst)
        (pg_fall && !fall_masked(wake_src)) |=> flags[BIT_PFALL]);

    p_fall_mask_r6: assert property (@(posedge clk) disable iff (rst)
        (pg_fall && fall_masked(wake_src) && !wr_en) |=> $stable(flags[BIT_PFALL]));

    p_keep_on_one_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[BIT_PRISE] && flags[BIT_PRISE]) |=> flags[BIT_PRISE]);

    p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
        (pg_rise && wr_en && !wr_data[BIT_PRISE]) |=> flags[BIT_PRISE]);

    p_col_rw_r9: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (flags[BIT_COL1:BIT_COL0] == $past(wr_data[BIT_COL1:BIT_COL0])));

    p_unused_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (flags[1:0] == 2'b00) && !flags[5]);

    p_irq_r10: assert property (@(posedge clk) disable iff (rst)
        irq == (irq_en && (flags[BIT_PRISE] || flags[BIT_PFALL])));
endmodule

bind wake_flag_reg wake_flag_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .btn_rise  (btn_rise),
    .pg_rise   (pg_rise),
    .pg_fall   (pg_fall),
    .sleep_req (sleep_req),
    .lcd_req   (lcd_req),
    .wake_src  (wake_src),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .irq_en    (irq_en),
    .flags     (flags),
    .irq       (irq)
);

// File: tb/tb_wake_flag_reg.sv
module tb_wake_flag_reg;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       btn_in = 0, pwr_good_in = 0, sleep_req = 0, lcd_req = 0;
    logic [1:0] wake_src = 0;
    logic       wr_en = 0;
    logic [7:0] wr_data = 0;
    logic       irq_en = 0;
    logic [7:0] flags;
    logic       irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // model state
    logic [7:0] m_flags = 0;
    logic [2:0] hb = 0, hp = 0;   // [0]=last sample, [1]=two back, [2]=three back

    always #5 clk = ~clk;

    wake_flag_reg dut (
        .clk(clk), .rst(rst), .btn_in(btn_in), .pwr_good_in(pwr_good_in),
        .sleep_req(sleep_req), .lcd_req(lcd_req), .wake_src(wake_src),
        .wr_en(wr_en), .wr_data(wr_data), .irq_en(irq_en),
        .flags(flags), .irq(irq)
    );

    function automatic string tag_of(input int b);
        case (b)
            2, 3:    return "R9";
            4:       return "R2";
            6:       return "R4";
            7:       return "R5";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one clock: model update at the edge, compare at the following falling edge
    task automatic step();
        @(posedge clk);
        if (rst) begin
            m_flags = 0; hb = 0; hp = 0;
        end else begin
            logic br, pr, pf;
            br = hb[1] & ~hb[2];
            pr = hp[1] & ~hp[2];
            pf = ~hp[1] & hp[2];
            if (br) m_flags[4] = 1;
            else if ((wr_en && !wr_data[4]) || sleep_req || lcd_req) m_flags[4] = 0;
            if (pr) m_flags[6] = 1;
            else if (wr_en && !wr_data[6]) m_flags[6] = 0;
            if (pf && !(wake_src == 2'd1 || wake_src == 2'd2)) m_flags[7] = 1;
            else if (wr_en && !wr_data[7]) m_flags[7] = 0;
            if (wr_en) m_flags[3:2] = wr_data[3:2];
            hb = {hb[1:0], btn_in};
            hp = {hp[1:0], pwr_good_in};
        end
        @(negedge clk);
        for (int b = 0; b < 8; b++)
            check(flags[b] === m_flags[b], tag_of(b), flags[b], m_flags[b]);
        check(irq === (irq_en & (m_flags[6] | m_flags[7])), "R10", irq,
              irq_en & (m_flags[6] | m_flags[7]));
    endtask

    task automatic idle(input int n);
        wr_en = 0; sleep_req = 0; lcd_req = 0;
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wr(input logic [7:0] d);
        wr_en = 1; wr_data = d; step(); wr_en = 0;
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'd2024);
        step(); step();
        check(flags === 8'h00, "R1", flags, 0);
        check(irq === 1'b0, "R1", irq, 0);
        rst = 0;
        idle(2);

        // R2: push-button rising edge
        btn_in = 1; idle(4);
        check(flags[4] === 1'b1, "R2", flags[4], 1);
        // R3: sleep and LCD requests clear it
        sleep_req = 1; step(); sleep_req = 0;
        check(flags[4] === 1'b0, "R3", flags[4], 0);
        btn_in = 0; idle(3); btn_in = 1; idle(4);
        lcd_req = 1; step(); lcd_req = 0;
        check(flags[4] === 1'b0, "R3", flags[4], 0);

        // R4 / R10
        pwr_good_in = 1; idle(4);
        check(flags[6] === 1'b1, "R4", flags[6], 1);
        irq_en = 1; #1;
        check(irq === 1'b1, "R10", irq, 1);
        irq_en = 0; #1;
        check(irq === 1'b0, "R10", irq, 0);

        // R7: write 1 keeps, write 0 clears
        wr(8'hFF);
        check(flags[6] === 1'b1, "R7", flags[6], 1);
        wr(8'h00);
        check(flags[6] === 1'b0, "R7", flags[6], 0);

        // R6: falling power-good during a push-button wake is masked
        wake_src = 2'd1; pwr_good_in = 0; idle(5);
        check(flags[7] === 1'b0, "R6", flags[7], 0);
        wake_src = 2'd2; pwr_good_in = 1; idle(4); pwr_good_in = 0; idle(5);
        check(flags[7] === 1'b0, "R6", flags[7], 0);
        // R5: unmasked fall sets
        wake_src = 2'd0; pwr_good_in = 1; idle(4); pwr_good_in = 0; idle(5);
        check(flags[7] === 1'b1, "R5", flags[7], 1);
        wr(8'h00);

        // R8: set event on the same edge as a written 0 and a sleep request
        btn_in = 0; idle(4);
        btn_in = 1; idle(2);
        wr_en = 1; wr_data = 8'h00; sleep_req = 1; step();
        wr_en = 0; sleep_req = 0;
        check(flags[4] === 1'b1, "R8", flags[4], 1);

        // R9: collision bits read/write, unused bits zero
        wr(8'hFF);
        check(flags[3:2] === 2'b11, "R9", flags[3:2], 3);
        check((flags & 8'h23) === 8'h00, "R9", flags, flags & 8'hDC);
        wr(8'h04);
        check(flags[3:2] === 2'b01, "R9", flags[3:2], 1);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 9) == 0) btn_in = ~btn_in;
            if ($urandom_range(0, 11) == 0) pwr_good_in = ~pwr_good_in;
            wake_src  = 2'($urandom_range(0, 3));
            sleep_req = ($urandom_range(0, 19) == 0);
            lcd_req   = ($urandom_range(0, 19) == 0);
            wr_en     = ($urandom_range(0, 7) == 0);
            wr_data   = 8'($urandom);
            irq_en    = 1'($urandom);
            step();
        end
        idle(1);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule